// File: doc/BRIEF.md
# Process-Tagged Address Translation Cache

This block caches page translations for a processor core. Each of its entries maps one virtual page number, under one process identifier, to a physical frame number. It also holds the page's access permissions, a modified flag and the identity of the entry touched most recently. The process identifier is part of the match key, so translations belonging to different processes can sit side by side. A context switch only needs the core to present a new identifier. No entry is discarded.

The core presents a virtual address, the access kind (load or store), the privilege mode and its current process identifier. In the same cycle the block reports one of three results: a clean hit with the physical address, a miss, or a permission fault. After a miss, the page-walk logic installs the entry through the fill port. The fill takes effect at the next clock edge.

The block chooses where a fill goes. It reuses a matching slot if one exists. Otherwise it takes the lowest empty slot, and when there is none it uses a rotating choice that never picks the most recently used slot. A small group of low-numbered slots belongs to the privileged context and is kept apart from ordinary fills. Two flush commands, one for everything and one for a single process, clear entries in one cycle.

Top module: `tlb_pid_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports a miss. While `lk_valid` is low, `lk_hit`, `lk_miss` and `lk_fault` are all low.
- R2: An entry matches a lookup only when it is valid, its page number equals `lk_va[31:12]` and its stored identifier equals `cur_pid`. On a clean hit, `lk_pa` is the stored 18-bit frame number followed by `lk_va[11:0]` unchanged.
- R3: Changing `cur_pid` invalidates nothing. Entries of a process whose identifier is switched away and back hit again, with their earlier frame numbers.
- R4: A matching access is a fault in three cases: a load to a page whose read permission is clear, a store to a page whose write permission is clear, or a user-mode access (`lk_user`=1) to a supervisor-only page. A fault raises `lk_fault` instead of `lk_hit`.
- R5: A fault changes neither the entry's modified flag nor the most-recently-used slot.
- R6: A store that hits cleanly sets that entry's modified flag. On a clean hit, `lk_dirty` shows the flag as it stood before the access.
- R7: A fill writes its entry at the next clock edge with the modified flag clear. If a valid entry with the same page number and identifier exists, that entry is overwritten in place and no other slot is used.
- R8: Without a matching entry, a fill takes the lowest-numbered invalid slot of its group. When the group is full, it takes the first slot of the group after the rotating pointer that is not the most recently used slot. The filled slot becomes the most recently used. A clean hit also makes its slot the most recently used.
- R9: Slots 0 to `RSV_N`-1 are filled only by privileged fills (`fill_priv`=1). Ordinary fills never pick them, and privileged fills never pick any other slot.
- R10: `inv_all` clears every entry, and `inv_pid_en` clears every entry whose identifier equals `inv_pid`. Either takes effect at the next clock edge and leaves all other entries usable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | 32 | Virtual address of the lookup |
| lk_store | input | 1 | 1 for a store, 0 for a load |
| lk_user | input | 1 | 1 when the access is made in user mode |
| cur_pid | input | 8 | Identifier of the running process |
| lk_hit | output | 1 | Clean hit |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Matching entry, permission violated |
| lk_dirty | output | 1 | Modified flag of the hit entry before this access |
| lk_pa | output | 30 | Physical address on a clean hit |
| fill_en | input | 1 | Install an entry at the next edge |
| fill_priv | input | 1 | Fill belongs to the privileged context |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pid | input | 8 | Process identifier to install |
| fill_pfn | input | 18 | Frame number to install |
| fill_rd | input | 1 | Read permission |
| fill_wr | input | 1 | Write permission |
| fill_sup | input | 1 | Page is supervisor-only |
| inv_all | input | 1 | Clear all entries |
| inv_pid_en | input | 1 | Clear entries of one process |
| inv_pid | input | 8 | Identifier for the per-process clear |

## Verification
One page number is installed under two identifiers and looked up under each, then under an identifier that owns nothing. This separates a tag that includes the process from one that compares the page only. Loads, stores and user-mode accesses go to pages with read-only, write-only and supervisor-only permissions, which separates each fault cause from a clean hit and shows that a fault leaves the modified flag and recency alone. Fills continue past capacity after chosen lookups and after a deliberate fault. Each resulting eviction, or its absence, shows whether the victim choice skipped the recently used slot, stepped the rotating pointer and kept the privileged group apart. The two flush commands are then applied to a mix of process and privileged entries.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W = 20;
    localparam int PFN_W = 18;
    localparam int PID_W = 8;
    localparam int OFS_W = 12;
    localparam int VA_W  = VPN_W + OFS_W;
    localparam int PA_W  = PFN_W + OFS_W;

    typedef struct packed {
        logic rd;
        logic wr;
        logic sup;
    } perm_t;

    typedef struct packed {
        logic             vld;
        logic             dirty;
        logic [PID_W-1:0] pid;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        perm_t            perm;
    } tlb_ent_t;

    // Permission check for an access that already matched an entry.
    function automatic logic perm_bad(perm_t p, logic is_store, logic is_user);
        logic kind_bad;
        kind_bad = is_store ? !p.wr : !p.rd;
        return kind_bad || (is_user && p.sup);
    endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]            vld,
    input  logic [N-1:0][VPN_W-1:0] tag_vpn,
    input  logic [N-1:0][PID_W-1:0] tag_pid,
    input  logic [VPN_W-1:0]        key_vpn,
    input  logic [PID_W-1:0]        key_pid,
    output logic [N-1:0]            hits,
    output logic                    hit_any,
    output logic [IDX_W-1:0]        hit_idx
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            assign hits[g] = vld[g] && (tag_vpn[g] == key_vpn) && (tag_pid[g] == key_pid);
        end
    endgenerate

    assign hit_any = |hits;

    // Encode the matching slot; at most one slot matches.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hits[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 16,
    parameter int RSV   = 2,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     vld,
    input  logic             priv,
    input  logic [IDX_W-1:0] mru,
    input  logic [IDX_W-1:0] ptr,
    output logic [IDX_W-1:0] vic_idx,
    output logic             vic_rot
);
    logic [N-1:0]     allowed;
    logic [N-1:0]     free;
    logic             have_free;
    logic             rot_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rot_idx;
    logic [IDX_W-1:0] first_ok;
    int               c;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_grp
            if (g < RSV) begin : g_rsv
                assign allowed[g] = priv;
            end else begin : g_ord
                assign allowed[g] = !priv;
            end
        end
    endgenerate

    assign free = allowed & ~vld;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end

        first_ok = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (allowed[i]) first_ok = IDX_W'(i);
        end

        // Walk forward from the slot after the pointer, skipping the MRU slot.
        rot_found = 1'b0;
        rot_idx   = '0;
        c         = 0;
        for (int k = 1; k <= N; k++) begin
            c = (int'(ptr) + k) % N;
            if (!rot_found && allowed[c] && (c != int'(mru))) begin
                rot_found = 1'b1;
                rot_idx   = IDX_W'(c);
            end
        end

        vic_rot = !have_free;
        vic_idx = have_free ? free_idx : (rot_found ? rot_idx : first_ok);
    end
endmodule

// File: rtl/tlb_pid_top.sv
module tlb_pid_top
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int RSV_N   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_va,
    input  logic             lk_store,
    input  logic             lk_user,
    input  logic [PID_W-1:0] cur_pid,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic             lk_dirty,
    output logic [PA_W-1:0]  lk_pa,
    input  logic             fill_en,
    input  logic             fill_priv,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PID_W-1:0] fill_pid,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_rd,
    input  logic             fill_wr,
    input  logic             fill_sup,
    input  logic             inv_all,
    input  logic             inv_pid_en,
    input  logic [PID_W-1:0] inv_pid
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int ORD_N = ENTRIES - RSV_N;

    tlb_ent_t [ENTRIES-1:0]            ent_q;
    logic     [ENTRIES-1:0]            vld_vec;
    logic     [ENTRIES-1:0]            dirty_vec;
    logic     [ENTRIES-1:0][VPN_W-1:0] tag_vpn;
    logic     [ENTRIES-1:0][PID_W-1:0] tag_pid;
    logic     [ENTRIES-1:0]            lk_hits;
    logic     [ENTRIES-1:0]            fl_hits;
    logic     [IDX_W-1:0]              lk_idx, fl_idx, vic_idx, fill_slot;
    logic     [IDX_W-1:0]              mru_q, ptr_q;
    logic                              lk_any, fl_any, vic_rot, lk_bad;
    tlb_ent_t                          fill_ent;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_view
            assign vld_vec[g]   = ent_q[g].vld;
            assign dirty_vec[g] = ent_q[g].dirty;
            assign tag_vpn[g]   = ent_q[g].vpn;
            assign tag_pid[g]   = ent_q[g].pid;
        end
    endgenerate

    // Lookup compare and fill compare share one CAM design.
    tlb_cam #(.N(ENTRIES), .IDX_W(IDX_W)) u_lk_cam (
        .vld(vld_vec), .tag_vpn(tag_vpn), .tag_pid(tag_pid),
        .key_vpn(lk_va[VA_W-1:OFS_W]), .key_pid(cur_pid),
        .hits(lk_hits), .hit_any(lk_any), .hit_idx(lk_idx)
    );

    tlb_cam #(.N(ENTRIES), .IDX_W(IDX_W)) u_fl_cam (
        .vld(vld_vec), .tag_vpn(tag_vpn), .tag_pid(tag_pid),
        .key_vpn(fill_vpn), .key_pid(fill_pid),
        .hits(fl_hits), .hit_any(fl_any), .hit_idx(fl_idx)
    );

    tlb_victim #(.N(ENTRIES), .RSV(RSV_N), .IDX_W(IDX_W)) u_victim (
        .vld(vld_vec), .priv(fill_priv), .mru(mru_q), .ptr(ptr_q),
        .vic_idx(vic_idx), .vic_rot(vic_rot)
    );

    // Lookup result, all in the request cycle.
    assign lk_bad   = perm_bad(ent_q[lk_idx].perm, lk_store, lk_user);
    assign lk_hit   = lk_valid && lk_any && !lk_bad;
    assign lk_fault = lk_valid && lk_any && lk_bad;
    assign lk_miss  = lk_valid && !lk_any;
    assign lk_dirty = lk_hit && ent_q[lk_idx].dirty;
    assign lk_pa    = lk_hit ? {ent_q[lk_idx].pfn, lk_va[OFS_W-1:0]} : '0;

    assign fill_slot = fl_any ? fl_idx : vic_idx;

    always_comb begin
        fill_ent.vld      = 1'b1;
        fill_ent.dirty    = 1'b0;
        fill_ent.pid      = fill_pid;
        fill_ent.vpn      = fill_vpn;
        fill_ent.pfn      = fill_pfn;
        fill_ent.perm.rd  = fill_rd;
        fill_ent.perm.wr  = fill_wr;
        fill_ent.perm.sup = fill_sup;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
            mru_q <= '0;
            ptr_q <= IDX_W'(ENTRIES - 1);
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (inv_all || (inv_pid_en && (ent_q[i].pid == inv_pid)))
                    ent_q[i].vld <= 1'b0;
                if (lk_hit && lk_store && (lk_idx == IDX_W'(i)))
                    ent_q[i].dirty <= 1'b1;
                if (fill_en && (fill_slot == IDX_W'(i)))
                    ent_q[i] <= fill_ent;
            end
            if (fill_en) begin
                mru_q <= fill_slot;
                if (!fl_any && vic_rot) ptr_q <= fill_slot;
            end else if (lk_hit) begin
                mru_q <= lk_idx;
            end
        end
    end

    // R7: a fill that matches replaces in place, so a key never sits twice
    p_one_match_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hits) && $onehot0(fl_hits));

    // R3: without a flush command no entry loses its valid bit
    p_valid_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (!inv_all && !inv_pid_en) |=> ((vld_vec & $past(vld_vec)) == $past(vld_vec)));

    // R5: a fault leaves modified flags and recency untouched
    p_fault_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (lk_fault && !fill_en) |=> ($stable(dirty_vec) && $stable(mru_q)));

    // R6: a clean store hit leaves its slot marked modified
    p_store_dirty_r6: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_store && !fill_en) |=> dirty_vec[$past(lk_idx)]);

    // R9: fresh fills stay inside their own group
    p_rsv_group_r9: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !fl_any) |->
            (fill_priv ? (int'(fill_slot) < RSV_N) : (int'(fill_slot) >= RSV_N)));

    // R8: a rotating choice never lands on the MRU slot when the group has another
    p_not_mru_r8: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !fl_any && vic_rot &&
         ((fill_priv && RSV_N > 1) || (!fill_priv && ORD_N > 1))) |-> (fill_slot != mru_q));

    // R10: a full flush empties the array by the next edge
    p_inv_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (inv_all && !fill_en) |=> (vld_vec == '0));
endmodule

// File: tb/sim_tlb_pid_top.sv
module sim_tlb_pid_top;
    import tlb_pkg::*;

    localparam logic [2:0] E_HIT  = 3'b100;
    localparam logic [2:0] E_MISS = 3'b010;
    localparam logic [2:0] E_FLT  = 3'b001;
    localparam logic [2:0] E_NONE = 3'b000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst, lk_valid, lk_store, lk_user;
    logic [VA_W-1:0]  lk_va;
    logic [PID_W-1:0] cur_pid;
    logic             lk_hit, lk_miss, lk_fault, lk_dirty;
    logic [PA_W-1:0]  lk_pa;
    logic             fill_en, fill_priv, fill_rd, fill_wr, fill_sup;
    logic [VPN_W-1:0] fill_vpn;
    logic [PID_W-1:0] fill_pid;
    logic [PFN_W-1:0] fill_pfn;
    logic             inv_all, inv_pid_en;
    logic [PID_W-1:0] inv_pid;

    tlb_pid_top u0 (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va), .lk_store(lk_store),
        .lk_user(lk_user), .cur_pid(cur_pid), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_fault(lk_fault), .lk_dirty(lk_dirty), .lk_pa(lk_pa), .fill_en(fill_en),
        .fill_priv(fill_priv), .fill_vpn(fill_vpn), .fill_pid(fill_pid), .fill_pfn(fill_pfn),
        .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_sup(fill_sup), .inv_all(inv_all),
        .inv_pid_en(inv_pid_en), .inv_pid(inv_pid)
    );

    int total = 0;
    int bad   = 0;

    // Scoreboard queues, one item per lookup cycle.
    logic [2:0]      kq[$];
    logic [PA_W-1:0] pq[$];
    logic            dq[$];
    string           tq[$];

    // Monitor: compares results 2 ns after the falling edge, well before the rising edge.
    always @(negedge clk) begin
        logic [2:0]      ek;
        logic [PA_W-1:0] ep;
        logic            ed;
        string           et;
        #2;
        if (tq.size() > 0) begin
            ek = kq.pop_front();
            ep = pq.pop_front();
            ed = dq.pop_front();
            et = tq.pop_front();
            total++;
            if ({lk_hit, lk_miss, lk_fault} !== ek) begin
                bad++;
                $display("FAIL %s result got=%b exp=%b", et, {lk_hit, lk_miss, lk_fault}, ek);
            end
            if (ek == E_HIT) begin
                total++;
                if (lk_pa !== ep) begin
                    bad++;
                    $display("FAIL %s pa got=%h exp=%h", et, lk_pa, ep);
                end
                total++;
                if (lk_dirty !== ed) begin
                    bad++;
                    $display("FAIL %s dirty got=%b exp=%b", et, lk_dirty, ed);
                end
            end
        end
    end

    task automatic look(input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid,
                        input logic st, input logic usr, input logic [2:0] e,
                        input logic [PFN_W-1:0] pfn, input logic d, input string tag);
        logic [OFS_W-1:0] off;
        off = vpn[OFS_W-1:0] ^ 12'h5A3;
        @(negedge clk);
        lk_valid = 1'b1;
        lk_va    = {vpn, off};
        lk_store = st;
        lk_user  = usr;
        cur_pid  = pid;
        kq.push_back(e);
        pq.push_back({pfn, off});
        dq.push_back(d);
        tq.push_back(tag);
        @(posedge clk);
        #1;
        lk_valid = 1'b0;
        lk_store = 1'b0;
    endtask

    task automatic quiet_chk(input string tag);
        @(negedge clk);
        lk_valid = 1'b0;
        kq.push_back(E_NONE);
        pq.push_back('0);
        dq.push_back(1'b0);
        tq.push_back(tag);
        @(posedge clk);
        #1;
    endtask

    task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid,
                        input logic [PFN_W-1:0] pfn, input logic priv,
                        input logic rd, input logic wr, input logic sup);
        @(negedge clk);
        fill_en   = 1'b1;
        fill_priv = priv;
        fill_vpn  = vpn;
        fill_pid  = pid;
        fill_pfn  = pfn;
        fill_rd   = rd;
        fill_wr   = wr;
        fill_sup  = sup;
        @(posedge clk);
        #1;
        fill_en   = 1'b0;
        fill_priv = 1'b0;
    endtask

    task automatic flush(input logic all, input logic by_pid, input logic [PID_W-1:0] pid);
        @(negedge clk);
        inv_all    = all;
        inv_pid_en = by_pid;
        inv_pid    = pid;
        @(posedge clk);
        #1;
        inv_all    = 1'b0;
        inv_pid_en = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(8 * 5000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; lk_valid = 1'b0; lk_va = '0; lk_store = 1'b0; lk_user = 1'b0;
        cur_pid = '0; fill_en = 1'b0; fill_priv = 1'b0; fill_vpn = '0; fill_pid = '0;
        fill_pfn = '0; fill_rd = 1'b0; fill_wr = 1'b0; fill_sup = 1'b0;
        inv_all = 1'b0; inv_pid_en = 1'b0; inv_pid = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: empty after reset, quiet when idle
        quiet_chk("R1 idle");
        look(20'h00010, 8'd5, 1'b0, 1'b1, E_MISS, '0, 1'b0, "R1 reset miss");

        // R7 / R2: install A (pid 5, rw) into slot 2
        fill(20'h00010, 8'd5, 18'h000AB, 1'b0, 1'b1, 1'b1, 1'b0);
        look(20'h00010, 8'd5, 1'b0, 1'b1, E_HIT, 18'h000AB, 1'b0, "R7 fill visible");
        look(20'h00010, 8'd6, 1'b0, 1'b1, E_MISS, '0, 1'b0, "R2 pid mismatch");
        look(20'h00011, 8'd5, 1'b0, 1'b1, E_MISS, '0, 1'b0, "R2 vpn mismatch");

        // R3: same page under pid 6 coexists, switching back still hits
        fill(20'h00010, 8'd6, 18'h000CD, 1'b0, 1'b1, 1'b1, 1'b0);
        look(20'h00010, 8'd6, 1'b0, 1'b1, E_HIT, 18'h000CD, 1'b0, "R3 pid6");
        look(20'h00010, 8'd5, 1'b0, 1'b1, E_HIT, 18'h000AB, 1'b0, "R3 pid5 kept");

        // C read-only (slot 4), D supervisor (slot 5), E write-only (slot 6)
        fill(20'h00020, 8'd5, 18'h00111, 1'b0, 1'b1, 1'b0, 1'b0);
        fill(20'h00030, 8'd5, 18'h00222, 1'b0, 1'b1, 1'b1, 1'b1);
        fill(20'h00040, 8'd5, 18'h00333, 1'b0, 1'b0, 1'b1, 1'b0);

        // R4: each permission cause
        look(20'h00020, 8'd5, 1'b1, 1'b1, E_FLT, '0, 1'b0, "R4 store ro");
        look(20'h00030, 8'd5, 1'b0, 1'b1, E_FLT, '0, 1'b0, "R4 user sup");
        look(20'h00030, 8'd5, 1'b0, 1'b0, E_HIT, 18'h00222, 1'b0, "R4 sup ok");
        look(20'h00040, 8'd5, 1'b0, 1'b1, E_FLT, '0, 1'b0, "R4 load no rd");
        look(20'h00040, 8'd5, 1'b1, 1'b1, E_HIT, 18'h00333, 1'b0, "R4 store wo");
        // R5: faulting store left the flag clear
        look(20'h00020, 8'd5, 1'b0, 1'b1, E_HIT, 18'h00111, 1'b0, "R5 no dirty on fault");

        // R6: store hit sets the flag, seen on the next hit
        look(20'h00010, 8'd5, 1'b1, 1'b1, E_HIT, 18'h000AB, 1'b0, "R6 store");
        look(20'h00010, 8'd5, 1'b0, 1'b1, E_HIT, 18'h000AB, 1'b1, "R6 dirty set");

        // R7: refill same key replaces in place, flag cleared
        fill(20'h00010, 8'd5, 18'h000EE, 1'b0, 1'b1, 1'b1, 1'b0);
        look(20'h00010, 8'd5, 1'b0, 1'b1, E_HIT, 18'h000EE, 1'b0, "R7 replace");

        // R8: invalid slots used first: slots 7..15
        for (int i = 0; i < 9; i++)
            fill(20'h00100 + 20'(i), 8'd7, 18'h00300 + 18'(i), 1'b0, 1'b1, 1'b1, 1'b0);
        look(20'h00010, 8'd6, 1'b0, 1'b1, E_HIT, 18'h000CD, 1'b0, "R8 no evict B");
        look(20'h00108, 8'd7, 1'b0, 1'b1, E_HIT, 18'h00308, 1'b0, "R8 last free");
        look(20'h00010, 8'd5, 1'b0, 1'b1, E_HIT, 18'h000EE, 1'b0, "R8 touch A");

        // R8: full; slot 2 is MRU so slot 3 (B) goes
        fill(20'h00200, 8'd7, 18'h00400, 1'b0, 1'b1, 1'b1, 1'b0);
        look(20'h00010, 8'd6, 1'b0, 1'b1, E_MISS, '0, 1'b0, "R8 B evicted");
        look(20'h00200, 8'd7, 1'b0, 1'b1, E_HIT, 18'h00400, 1'b0, "R8 F present");
        look(20'h00010, 8'd5, 1'b0, 1'b1, E_HIT, 18'h000EE, 1'b0, "R8 A kept");
        // pointer advanced: slot 4 (C) goes next
        fill(20'h00201, 8'd7, 18'h00401, 1'b0, 1'b1, 1'b1, 1'b0);
        look(20'h00020, 8'd5, 1'b0, 1'b1, E_MISS, '0, 1'b0, "R8 C evicted");
        look(20'h00201, 8'd7, 1'b0, 1'b1, E_HIT, 18'h00401, 1'b0, "R8 G present");

        // R5: fault on D (slot 5) must not make it MRU; next fill takes slot 5
        look(20'h00030, 8'd5, 1'b0, 1'b1, E_FLT, '0, 1'b0, "R5 fault D");
        fill(20'h00202, 8'd7, 18'h00402, 1'b0, 1'b1, 1'b1, 1'b0);
        look(20'h00030, 8'd5, 1'b0, 1'b0, E_MISS, '0, 1'b0, "R5 D evicted");
        look(20'h00040, 8'd5, 1'b1, 1'b1, E_HIT, 18'h00333, 1'b1, "R5 E kept");

        // R9: privileged fills go to slots 0 and 1
        fill(20'h00300, 8'd0, 18'h00500, 1'b1, 1'b1, 1'b1, 1'b1);
        fill(20'h00301, 8'd0, 18'h00501, 1'b1, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 14; i++)
            fill(20'h00400 + 20'(i), 8'd9, 18'h00600 + 18'(i), 1'b0, 1'b1, 1'b1, 1'b0);
        look(20'h00400, 8'd9, 1'b0, 1'b1, E_HIT, 18'h00600, 1'b0, "R9 Q0");
        look(20'h0040D, 8'd9, 1'b0, 1'b1, E_HIT, 18'h0060D, 1'b0, "R9 Q13");
        look(20'h00301, 8'd0, 1'b0, 1'b0, E_HIT, 18'h00501, 1'b0, "R9 P1 kept");
        look(20'h00300, 8'd0, 1'b0, 1'b1, E_FLT, '0, 1'b0, "R4 user on priv");
        look(20'h00300, 8'd0, 1'b0, 1'b0, E_HIT, 18'h00500, 1'b0, "R9 P0 kept");
        // R9: privileged group full, slot 0 is MRU, so slot 1 goes
        fill(20'h00302, 8'd0, 18'h00502, 1'b1, 1'b1, 1'b1, 1'b1);
        look(20'h00301, 8'd0, 1'b0, 1'b0, E_MISS, '0, 1'b0, "R9 P1 evicted");
        look(20'h00302, 8'd0, 1'b0, 1'b0, E_HIT, 18'h00502, 1'b0, "R9 P2");
        look(20'h00300, 8'd0, 1'b0, 1'b0, E_HIT, 18'h00500, 1'b0, "R9 P0");
        look(20'h00400, 8'd9, 1'b0, 1'b1, E_HIT, 18'h00600, 1'b0, "R9 ordinary untouched");

        // R10: per-process then full flush
        flush(1'b0, 1'b1, 8'd9);
        look(20'h00400, 8'd9, 1'b0, 1'b1, E_MISS, '0, 1'b0, "R10 pid flush Q0");
        look(20'h0040D, 8'd9, 1'b0, 1'b1, E_MISS, '0, 1'b0, "R10 pid flush Q13");
        look(20'h00300, 8'd0, 1'b0, 1'b0, E_HIT, 18'h00500, 1'b0, "R10 other pid kept");
        flush(1'b1, 1'b0, 8'd0);
        look(20'h00300, 8'd0, 1'b0, 1'b0, E_MISS, '0, 1'b0, "R10 all P0");
        look(20'h00302, 8'd0, 1'b0, 1'b0, E_MISS, '0, 1'b0, "R10 all P2");

        repeat (3) @(negedge clk);
        #3;
        summary();
        $finish;
    end
endmodule